// File: doc/BRIEF.md
# Weighted Deficit Round Robin Packet Scheduler with Output Rate Cap

This block decides which of several packet queues sends next on a shared output. Each arrival carries a queue number and a packet length in bytes. The block stores only the lengths, one small FIFO per queue. The packet data itself lives elsewhere. When the output is ready, the block names the queue and the length of the packet that leaves now.

Queues are served by weighted deficit round robin. Each queue holds a byte credit, called the deficit. On each visit, the queue's weight (its quantum) is added to that credit. The queue may then send head packets as long as each one fits in the remaining credit.

Two controls bound the scheduler:
- A per-queue packet-count limit. Arrivals beyond the limit are refused and counted.
- A token bucket on the aggregate output. It caps the total bytes released, whichever queues are sending.

Several schedulers with independent state are obtained by instantiating the block several times.

Top module: `wdrr_sched`

## Requirements
- R1: After reset `deq_valid` is low, every drop count reads zero, every queue is empty, and no dequeue is offered until packets have been accepted.
- R2: An arrival (`enq_valid` high) to queue `enq_qid` is refused when that queue already holds at least its configured limit, or holds `DEPTH` (16) packets.
  - `enq_drop` is high in the same cycle as a refused arrival.
  - A refused arrival is never served.
  - A limit of 0 refuses every arrival.
- R3: Each refused arrival adds one to its queue's drop count. The count for queue `cfg_rd_qid` appears on `cfg_drops` in the same cycle.
- R4: Within one queue, packets leave in arrival order. `deq_len` equals the length given at enqueue, in bytes (64 to 2048, binary). `deq_qid` is the binary queue number.
- R5: When the scheduler arrives at a non-empty queue, the queue's quantum is added to its deficit. Head packets are then sent while their length does not exceed the deficit. Each packet sent reduces the deficit by its length.
- R6: When the head packet is longer than the deficit, the scheduler moves on to the next queue in increasing index order. After the last queue it wraps to queue 0. The leftover deficit is kept for the next visit. After reset the scheduler starts at queue 0.
- R7: A queue emptied by a dequeue has its deficit cleared, and the scheduler moves on. An empty queue is passed over with a zero deficit.
- R8: The token bucket is empty at reset. Each cycle it gains `cfg_rate` bytes, after subtracting the length released in that cycle, and it is capped at `cfg_burst`. A packet is offered only when the bucket holds at least its length. From the cycle `deq_ready` first rises, the bytes released over k cycles never exceed `cfg_burst` plus k times `cfg_rate`.
- R9: While `deq_ready` is low, the round is frozen. No dequeue happens, no deficit changes, and the scheduler stays on the same queue. The service order is therefore unaffected by pauses.
- R10: A cycle with `cfg_we` high writes `cfg_quantum` and `cfg_limit` into the queue selected by `cfg_qid`. After reset every quantum is 0 and every limit is `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write quantum and limit of queue `cfg_qid` |
| cfg_qid | input | QW | Queue selected for a configuration write |
| cfg_quantum | input | LENW | Bytes added to the deficit on each visit |
| cfg_limit | input | CW | Maximum packets the queue may hold |
| cfg_rate | input | TOKW | Bytes added to the token bucket per cycle |
| cfg_burst | input | TOKW | Token bucket capacity in bytes |
| cfg_rd_qid | input | QW | Queue whose drop count is shown |
| cfg_drops | output | DCW | Drop count of queue `cfg_rd_qid` |
| enq_valid | input | 1 | An arrival is presented |
| enq_qid | input | QW | Queue of the arrival |
| enq_len | input | LENW | Packet length in bytes |
| enq_drop | output | 1 | The presented arrival is refused |
| deq_ready | input | 1 | Output can take a packet; the round advances only while high |
| deq_valid | output | 1 | A dequeue decision is offered |
| deq_qid | output | QW | Queue of the offered packet |
| deq_len | output | LENW | Length of the offered packet |

## Verification
Each scenario loads its queues with the output held off, then releases the output. The order of departures is compared against a packet-level model of the round.

Equal quanta with equal lengths show whether the scheduler alternates fairly and wraps. Unequal quanta show whether the share follows the weights. Lengths far larger than the quantum tell whether leftover credit is carried across visits and cleared on emptying.

Overfilled queues, a zero limit and a limit above the FIFO depth separate the threshold path from the full path. A low token rate, checked against a byte bound over time, shows whether the aggregate cap is honoured. A service run with frequent output pauses shows that stalls leave the order unchanged.

// File: rtl/wdrr_sched.sv
module wdrr_sched #(
  parameter int NQ    = 8,
  parameter int DEPTH = 16,
  parameter int LENW  = 12,
  parameter int TOKW  = 16,
  parameter int DCW   = 16,
  localparam int QW   = $clog2(NQ),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [QW-1:0]   cfg_qid,
  input  logic [LENW-1:0] cfg_quantum,
  input  logic [CW-1:0]   cfg_limit,
  input  logic [TOKW-1:0] cfg_rate,
  input  logic [TOKW-1:0] cfg_burst,
  input  logic [QW-1:0]   cfg_rd_qid,
  output logic [DCW-1:0]  cfg_drops,
  input  logic            enq_valid,
  input  logic [QW-1:0]   enq_qid,
  input  logic [LENW-1:0] enq_len,
  output logic            enq_drop,
  input  logic            deq_ready,
  output logic            deq_valid,
  output logic [QW-1:0]   deq_qid,
  output logic [LENW-1:0] deq_len
);
  localparam int AW   = $clog2(DEPTH);
  localparam int DEFW = LENW + 2;

  logic [LENW-1:0] mem   [NQ][DEPTH];
  logic [AW-1:0]   wp    [NQ];
  logic [AW-1:0]   rp    [NQ];
  logic [CW-1:0]   cnt   [NQ];
  logic [LENW-1:0] quant [NQ];
  logic [CW-1:0]   lim   [NQ];
  logic [DCW-1:0]  drops [NQ];
  logic [DEFW-1:0] dfc   [NQ];
  logic [QW-1:0]   ptr;
  logic            fresh;
  logic [TOKW-1:0] tok;

  logic [LENW-1:0] head_len;
  logic            enq_ok, fits, pop;
  logic [QW-1:0]   nxt;
  logic [TOKW:0]   tsum;

  assign head_len  = mem[ptr][rp[ptr]];
  assign enq_drop  = enq_valid && (cnt[enq_qid] >= lim[enq_qid] || cnt[enq_qid] == CW'(DEPTH));
  assign enq_ok    = enq_valid && !enq_drop;
  assign fits      = DEFW'(head_len) <= dfc[ptr];
  assign deq_valid = (cnt[ptr] != '0) && !fresh && fits && (TOKW'(head_len) <= tok);
  assign pop       = deq_valid && deq_ready;
  assign deq_qid   = ptr;
  assign deq_len   = head_len;
  assign cfg_drops = drops[cfg_rd_qid];
  assign nxt       = (ptr == QW'(NQ - 1)) ? '0 : ptr + 1'b1;
  assign tsum      = {1'b0, tok} - (pop ? (TOKW+1)'(head_len) : '0) + {1'b0, cfg_rate};

  always_ff @(posedge clk)
    if (enq_ok) mem[enq_qid][wp[enq_qid]] <= enq_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        wp[q] <= '0; rp[q] <= '0; cnt[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (enq_ok && enq_qid == QW'(q)) wp[q] <= wp[q] + 1'b1;
        if (pop && ptr == QW'(q))        rp[q] <= rp[q] + 1'b1;
        cnt[q] <= cnt[q] + CW'(enq_ok && enq_qid == QW'(q)) - CW'(pop && ptr == QW'(q));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        quant[q] <= '0; lim[q] <= CW'(DEPTH); drops[q] <= '0;
      end
    end else begin
      if (cfg_we) begin
        quant[cfg_qid] <= cfg_quantum;
        lim[cfg_qid]   <= cfg_limit;
      end
      if (enq_drop) drops[enq_qid] <= drops[enq_qid] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok <= '0;
    else        tok <= (tsum > {1'b0, cfg_burst}) ? cfg_burst : tsum[TOKW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      fresh <= 1'b1;
      for (int q = 0; q < NQ; q++) dfc[q] <= '0;
    end else if (deq_ready) begin
      if (cnt[ptr] == '0) begin
        dfc[ptr] <= '0; ptr <= nxt; fresh <= 1'b1;
      end else if (fresh) begin
        dfc[ptr] <= dfc[ptr] + DEFW'(quant[ptr]); fresh <= 1'b0;
      end else if (!fits) begin
        ptr <= nxt; fresh <= 1'b1;
      end else if (pop) begin
        if (cnt[ptr] == CW'(1)) begin
          dfc[ptr] <= '0; ptr <= nxt; fresh <= 1'b1;
        end else begin
          dfc[ptr] <= dfc[ptr] - DEFW'(head_len);
        end
      end
    end
  end

  p_drop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_drop |=> drops[$past(enq_qid)] == $past(drops[enq_qid]) + 1'b1);

  p_debit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && cnt[ptr] > CW'(1) |=> dfc[$past(ptr)] == $past(dfc[ptr]) - DEFW'($past(deq_len)));

  p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && cnt[ptr] == CW'(1) |=> dfc[$past(ptr)] == '0 && fresh);

  p_bucket_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> tok <= $past(cfg_burst));

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_ready |=> $stable(ptr) && $stable(fresh));

  p_no_overfill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && cnt[enq_qid] == CW'(DEPTH) |-> enq_drop);
endmodule

// File: tb/sim_wdrr_sched.sv
module sim_wdrr_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_qid = 0, cfg_rd_qid = 0;
  logic [11:0] cfg_quantum = 0;
  logic [4:0]  cfg_limit = 0;
  logic [15:0] cfg_rate = 0, cfg_burst = 0;
  logic [15:0] cfg_drops;
  logic        enq_valid = 0, enq_drop;
  logic [2:0]  enq_qid = 0;
  logic [11:0] enq_len = 0;
  logic        deq_ready = 0, deq_valid;
  logic [2:0]  deq_qid;
  logic [11:0] deq_len;

  wdrr_sched u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int exp_q[$];
  int mq[NQ][$];
  int mdef[NQ], mquant[NQ], mlim[NQ], mdrops[NQ];
  int mptr;
  int out_bytes, run_cyc, last_cyc;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (deq_ready) run_cyc++;
    if (rst_n && deq_valid && deq_ready) begin
      out_bytes += deq_len;
      last_cyc = run_cyc;
      if (exp_q.size() == 0)
        check(0, "R1/R9 unexpected dequeue", int'(deq_qid) * 65536 + int'(deq_len), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(deq_qid) * 65536 + int'(deq_len) == e, "R4/R5/R6/R7 order",
              int'(deq_qid) * 65536 + int'(deq_len), e);
      end
      if (cfg_rate < 16'd1000)
        check(out_bytes <= int'(cfg_burst) + int'(cfg_rate) * run_cyc, "R8 byte bound",
              out_bytes, int'(cfg_burst) + int'(cfg_rate) * run_cyc);
    end
  end

  task automatic do_reset(int rate, int burst);
    @(posedge clk); #1;
    rst_n = 0; deq_ready = 0; enq_valid = 0; cfg_we = 0;
    cfg_rate = 16'(rate); cfg_burst = 16'(burst);
    exp_q.delete();
    for (int q = 0; q < NQ; q++) begin
      mq[q].delete(); mdef[q] = 0; mquant[q] = 0; mlim[q] = 16; mdrops[q] = 0;
    end
    mptr = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic cfg(int q, int quantum, int limit);
    @(posedge clk); #1;
    cfg_we = 1; cfg_qid = 3'(q); cfg_quantum = 12'(quantum); cfg_limit = 5'(limit);
    mquant[q] = quantum; mlim[q] = limit;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic enq(int q, int len);
    bit exp_drop;
    @(posedge clk); #1;
    enq_valid = 1; enq_qid = 3'(q); enq_len = 12'(len);
    exp_drop = (mq[q].size() >= mlim[q]) || (mq[q].size() == 16);
    #2;
    check(enq_drop == exp_drop, "R2 enq_drop", int'(enq_drop), int'(exp_drop));
    if (exp_drop) mdrops[q]++;
    else mq[q].push_back(len);
    @(posedge clk); #1 enq_valid = 0;
  endtask

  task automatic model_run();
    int total;
    total = 0;
    for (int q = 0; q < NQ; q++) total += mq[q].size();
    while (total > 0) begin
      int q;
      q = mptr;
      if (mq[q].size() == 0) mdef[q] = 0;
      else begin
        mdef[q] += mquant[q];
        while (mq[q].size() > 0 && mq[q][0] <= mdef[q]) begin
          int l;
          l = mq[q].pop_front();
          mdef[q] -= l; total--;
          exp_q.push_back(q * 65536 + l);
          if (mq[q].size() == 0) mdef[q] = 0;
        end
      end
      mptr = (mptr + 1) % NQ;
    end
  endtask

  task automatic serve(int gappy, int maxcyc);
    int n;
    model_run();
    out_bytes = 0; run_cyc = 0; last_cyc = 0;
    n = 0;
    @(posedge clk); #1 deq_ready = 1;
    while (exp_q.size() > 0 && n < maxcyc) begin
      @(posedge clk); #1;
      n++;
      if (gappy != 0) deq_ready = (n % 3) != 0;
    end
    deq_ready = 1;
    repeat (6) @(posedge clk);
    #1 deq_ready = 0;
    check(exp_q.size() == 0, "R5 all expected packets served", exp_q.size(), 0);
  endtask

  task automatic check_drops(string req);
    for (int q = 0; q < NQ; q++) begin
      @(posedge clk); #1 cfg_rd_qid = 3'(q);
      #2 check(int'(cfg_drops) == mdrops[q], req, int'(cfg_drops), mdrops[q]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(4096, 65535);
    #2 check(deq_valid == 0, "R1 deq_valid after reset", int'(deq_valid), 0);
    check_drops("R1 drop count zero");
    @(posedge clk); #1 deq_ready = 1;
    repeat (20) @(posedge clk);
    #1 deq_ready = 0;

    // R5/R6 equal weights, wrap across queues
    do_reset(4096, 65535);
    for (int q = 0; q < 4; q++) cfg(q, 64, 16);
    for (int i = 0; i < 3; i++) for (int q = 0; q < 4; q++) enq(q, 64);
    serve(0, 400);

    // R5/R6/R10 unequal weights, mixed lengths
    do_reset(4096, 65535);
    cfg(1, 128, 16); cfg(6, 512, 16);
    for (int i = 0; i < 6; i++) begin enq(1, 64 + 32 * i); enq(6, 128 + 64 * i); end
    serve(0, 600);

    // R6/R7 long packets carry deficit; emptying clears it
    do_reset(4096, 65535);
    cfg(0, 500, 16); cfg(7, 400, 16); cfg(3, 100, 16);
    enq(0, 1500); enq(0, 64); enq(0, 700);
    enq(7, 300); enq(7, 300); enq(7, 2048);
    enq(3, 150);
    serve(0, 2000);

    // R2/R3 threshold, full FIFO and zero-limit refusals
    do_reset(4096, 65535);
    cfg(2, 256, 3); cfg(5, 2048, 20); cfg(4, 256, 0);
    for (int i = 0; i < 5; i++) enq(2, 100 + i);
    for (int i = 0; i < 18; i++) enq(5, 64 + i);
    enq(4, 64); enq(4, 64);
    check_drops("R3 drop counts");
    serve(0, 1000);

    // R9 output pauses leave order unchanged
    do_reset(4096, 65535);
    cfg(0, 200, 16); cfg(2, 300, 16); cfg(5, 64, 16);
    for (int i = 0; i < 5; i++) begin enq(0, 90 + i); enq(2, 150); enq(5, 64); end
    serve(1, 1500);

    // R8 token bucket caps aggregate output
    do_reset(8, 256);
    cfg(0, 2048, 16);
    for (int i = 0; i < 10; i++) enq(0, 64);
    serve(0, 400);
    check(last_cyc >= 40, "R8 rate limited duration", last_cyc, 40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule